// File: doc/BRIEF.md
# Two-Layer Checkpoint Watchdog with Fault Localisation

This block supervises a design that is divided into two nested layers of work. Each layer reports progress by presenting a checkpoint number together with a one-cycle kick strobe. The checkpoint numbers of a layer must climb by one from zero up to a programmed final value and then start again at zero. Each layer also has its own countdown window, and a correct kick must arrive before that window runs out. The outer layer's checkpoints fall between the inner layer's checkpoints, but the two layers are checked independently of each other.

A layer that misses its window, or that reports a checkpoint out of order, emits a one-cycle exception. A central handler stores the exceptions in arrival order, in a short history. Each entry records the layer, the kind of violation and the last checkpoint that layer passed correctly. The first violation is taken as the origin of the fault. Any stored exception requests a retry of the failed function. Once the number of stored exceptions reaches a programmable threshold, the handler asks for a full reset instead and reports which layer failed first. Acknowledging the request wipes the history and restarts both layers.

Top module: `ckwd_top`

## Requirements
- R1: When a running layer receives no correct kick for T consecutive clock edges after its window was last restarted, it pulses its exception bit for exactly one cycle with its order bit at 0 (timeout). T is that layer's timeout input, and a value of 0 is treated as 1.
- R2: A kick is correct if its index equals the expected index. A correct kick restarts the window and records the index as the last good checkpoint. It also sets the expected index to index+1, or to 0 if the index equals that layer's final-index input. After reset or clear, the expected index is 0.
- R3: A kick with any other index raises a one-cycle exception with the order bit at 1. It leaves the expected index unchanged and does not restart the window.
- R4: After a timeout the layer stays frozen until clear. While frozen it raises no further exceptions and ignores all kicks.
- R5: A wrong kick on the same edge as a timeout is reported as a timeout (order bit 0).
- R6: Each layer's timer, expected index and exceptions depend only on that layer's own inputs.
- R7: The handler appends exceptions to a four-entry history in arrival order. When both layers raise an exception in the same cycle, the inner layer (bit 0) is stored first. `rec_req` is high while the history is non-empty.
- R8: `rec_full` and `fault_valid` are high when the number of stored entries reaches the threshold. The threshold is taken from `exc_thresh`, with 0 treated as 1 and values above 4 treated as 4. Below the threshold, a request with `rec_full` low means retry.
- R9: While `fault_valid` is high, the following describe the oldest entry: `fault_layer` is one-hot with bit 0 for the inner layer and bit 1 for the outer layer, `fault_idx` is that layer's last good checkpoint (0 if none since clear), and `fault_order` is its order bit. All three are 0 otherwise.
- R10: `rec_ack` sampled high while `rec_req` is high clears the history, the timers, the expected indices and the freeze. Any exception or kick in that same cycle is discarded.
- R11: After reset, all outputs are 0 and both layers expect index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick | input | 2 | Kick strobe per layer, bit 0 inner |
| idx | input | 8 | Checkpoint index per layer, 4 bits each, inner in the low bits |
| tmo | input | 32 | Window length per layer in cycles, 16 bits each |
| last_idx | input | 8 | Final index of a pass per layer |
| exc_thresh | input | 3 | Number of stored exceptions that calls for a full reset |
| rec_ack | input | 1 | Acknowledge of the recovery request |
| exc_pulse | output | 2 | One-cycle exception per layer |
| exc_order | output | 2 | Exception is an order violation (valid with exc_pulse) |
| rec_req | output | 1 | Recovery requested |
| rec_full | output | 1 | Requested recovery is a full reset rather than a retry |
| fault_valid | output | 1 | Fault location is available |
| fault_layer | output | 2 | One-hot layer of the first recorded exception |
| fault_idx | output | 4 | Last good checkpoint of that layer |
| fault_order | output | 1 | First recorded exception was an order violation |

## Verification
The assertions assume two things about the inputs. First, `rec_ack` is only meaningful while a request is outstanding. Second, the timeout and final-index inputs change only while the layer is idle or being cleared, so a window never shrinks below a count that is already running. The stimulus keeps within these limits: it changes configuration only right after an acknowledge, and it raises `rec_ack` only while `rec_req` is high. The exception in R10 is the one case that deliberately collides an acknowledge with a wrong kick. Wrong indices are always formed as the expected index plus one, modulo the pass length, so every such kick is a true order violation.

// File: rtl/ckwd_pkg.sv
package ckwd_pkg;
  typedef enum logic {
    EXC_TIMEOUT = 1'b0,
    EXC_ORDER   = 1'b1
  } exc_kind_e;
endpackage

// File: rtl/ckwd_layer.sv
module ckwd_layer
  import ckwd_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             kick,
  input  logic [IDX_W-1:0] idx,
  input  logic [TMR_W-1:0] tmo,
  input  logic [IDX_W-1:0] last,
  output logic             exc,
  output logic             exc_ord,
  output logic [IDX_W-1:0] last_good
);

  function automatic logic [TMR_W-1:0] window_len(input logic [TMR_W-1:0] t);
    return (t == '0) ? TMR_W'(1) : t;
  endfunction

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] cur,
                                                input logic [IDX_W-1:0] fin);
    return (cur == fin) ? '0 : cur + IDX_W'(1);
  endfunction

  logic [TMR_W-1:0] elapsed;
  logic [IDX_W-1:0] expd;
  logic [IDX_W-1:0] good_q;
  logic             frozen;
  logic             exc_q;
  exc_kind_e        kind_q;

  // named events
  logic kick_ok, tmo_hit, ord_bad;
  assign kick_ok = !frozen && kick && (idx == expd);
  assign tmo_hit = !frozen && !kick_ok && (elapsed >= window_len(tmo) - TMR_W'(1));
  assign ord_bad = !frozen && kick && !kick_ok && !tmo_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= '0;
      expd    <= '0;
      good_q  <= '0;
      frozen  <= 1'b0;
      exc_q   <= 1'b0;
      kind_q  <= EXC_TIMEOUT;
    end else if (clr) begin
      elapsed <= '0;
      expd    <= '0;
      good_q  <= '0;
      frozen  <= 1'b0;
      exc_q   <= 1'b0;
      kind_q  <= EXC_TIMEOUT;
    end else begin
      exc_q  <= tmo_hit || ord_bad;
      kind_q <= ord_bad ? EXC_ORDER : EXC_TIMEOUT;
      if (kick_ok) begin
        elapsed <= '0;
        expd    <= step_idx(idx, last);
        good_q  <= idx;
      end else if (tmo_hit) begin
        frozen <= 1'b1;
      end else if (!frozen) begin
        elapsed <= elapsed + TMR_W'(1);
      end
    end
  end

  assign exc       = exc_q;
  assign exc_ord   = exc_q && (kind_q == EXC_ORDER);
  assign last_good = good_q;

  // R4: a timeout is reported once, the stall then stays silent
  assert_single_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_q && kind_q == EXC_TIMEOUT) |=> !exc_q);

  // R4: a layer frozen across a whole cycle raises nothing
  assert_frozen_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && $past(frozen)) |-> !exc_q);

  // R3: an order exception always follows a kick
  assert_order_needs_kick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_q && kind_q == EXC_ORDER) |-> $past(kick));

endmodule

// File: rtl/ckwd_handler.sv
module ckwd_handler #(
  parameter int NL    = 2,
  parameter int IDX_W = 4,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NL-1:0]              exc,
  input  logic [NL-1:0]              exc_ord,
  input  logic [NL*IDX_W-1:0]        good,
  input  logic [$clog2(DEPTH+1)-1:0] thresh,
  input  logic                       rec_ack,
  output logic                       clr,
  output logic                       rec_req,
  output logic                       rec_full,
  output logic                       fault_valid,
  output logic [NL-1:0]              fault_layer,
  output logic [IDX_W-1:0]           fault_idx,
  output logic                       fault_order
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(NL);

  function automatic logic [CW-1:0] eff_thresh(input logic [CW-1:0] t);
    if (t == '0)            return CW'(1);
    else if (t > CW'(DEPTH)) return CW'(DEPTH);
    else                     return t;
  endfunction

  logic [LW-1:0]    r_lay  [DEPTH];
  logic             r_ord  [DEPTH];
  logic [IDX_W-1:0] r_good [DEPTH];
  logic [CW-1:0]    cnt;

  logic [LW-1:0]    n_lay  [DEPTH];
  logic             n_ord  [DEPTH];
  logic [IDX_W-1:0] n_good [DEPTH];
  logic [CW-1:0]    n_cnt;

  assign clr = rec_ack && rec_req;

  // append this cycle's exceptions, lowest layer first, while room remains
  always_comb begin
    n_lay  = r_lay;
    n_ord  = r_ord;
    n_good = r_good;
    n_cnt  = cnt;
    for (int l = 0; l < NL; l++) begin
      if (exc[l] && n_cnt < CW'(DEPTH)) begin
        n_lay[PW'(n_cnt)]  = LW'(l);
        n_ord[PW'(n_cnt)]  = exc_ord[l];
        n_good[PW'(n_cnt)] = good[l*IDX_W +: IDX_W];
        n_cnt              = n_cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int d = 0; d < DEPTH; d++) begin
        r_lay[d]  <= '0;
        r_ord[d]  <= 1'b0;
        r_good[d] <= '0;
      end
    end else if (clr) begin
      cnt <= '0;
    end else begin
      cnt    <= n_cnt;
      r_lay  <= n_lay;
      r_ord  <= n_ord;
      r_good <= n_good;
    end
  end

  assign rec_req     = (cnt != '0);
  assign rec_full    = (cnt >= eff_thresh(thresh));
  assign fault_valid = rec_full;
  assign fault_layer = fault_valid ? (NL'(1) << r_lay[0]) : '0;
  assign fault_idx   = fault_valid ? r_good[0] : '0;
  assign fault_order = fault_valid && r_ord[0];

  // R8: a full-reset request is always a request
  assert_full_is_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_full |-> rec_req);

  // R10: an accepted acknowledge empties the history
  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_ack && rec_req) |=> (!rec_req && !fault_valid));

  // R9: the located layer is a single one
  assert_fault_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> ($countones(fault_layer) == 1));

  // R7: an exception makes the request visible next cycle unless cleared
  assert_exc_requests_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((exc != '0) && !clr) |=> rec_req);

endmodule

// File: rtl/ckwd_top.sv
module ckwd_top #(
  parameter int NL    = 2,
  parameter int IDX_W = 4,
  parameter int TMR_W = 16,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NL-1:0]              kick,
  input  logic [NL*IDX_W-1:0]        idx,
  input  logic [NL*TMR_W-1:0]        tmo,
  input  logic [NL*IDX_W-1:0]        last_idx,
  input  logic [$clog2(DEPTH+1)-1:0] exc_thresh,
  input  logic                       rec_ack,
  output logic [NL-1:0]              exc_pulse,
  output logic [NL-1:0]              exc_order,
  output logic                       rec_req,
  output logic                       rec_full,
  output logic                       fault_valid,
  output logic [NL-1:0]              fault_layer,
  output logic [IDX_W-1:0]           fault_idx,
  output logic                       fault_order
);

  logic                clr_all;
  logic [NL*IDX_W-1:0] good_flat;

  for (genvar g = 0; g < NL; g++) begin : g_layer
    ckwd_layer #(
      .IDX_W (IDX_W),
      .TMR_W (TMR_W)
    ) u_layer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr_all),
      .kick      (kick[g]),
      .idx       (idx[g*IDX_W +: IDX_W]),
      .tmo       (tmo[g*TMR_W +: TMR_W]),
      .last      (last_idx[g*IDX_W +: IDX_W]),
      .exc       (exc_pulse[g]),
      .exc_ord   (exc_order[g]),
      .last_good (good_flat[g*IDX_W +: IDX_W])
    );
  end

  ckwd_handler #(
    .NL    (NL),
    .IDX_W (IDX_W),
    .DEPTH (DEPTH)
  ) u_handler (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc         (exc_pulse),
    .exc_ord     (exc_order),
    .good        (good_flat),
    .thresh      (exc_thresh),
    .rec_ack     (rec_ack),
    .clr         (clr_all),
    .rec_req     (rec_req),
    .rec_full    (rec_full),
    .fault_valid (fault_valid),
    .fault_layer (fault_layer),
    .fault_idx   (fault_idx),
    .fault_order (fault_order)
  );

  // R11: nothing is reported from reset until an exception has been seen
  assert_quiet_until_exc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rec_req && exc_pulse == '0) |=> !fault_valid);

endmodule

// File: tb/sim_ckwd_top.sv
`timescale 1ns/1ps
module sim_ckwd_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] kick = '0;
  logic [7:0] idx = '0;
  logic [31:0] tmo = '0;
  logic [7:0] last_idx = '0;
  logic [2:0] exc_thresh = 3'd3;
  logic       rec_ack = 1'b0;
  logic [1:0] exc_pulse, exc_order, fault_layer;
  logic       rec_req, rec_full, fault_valid, fault_order;
  logic [3:0] fault_idx;

  always #5 clk = ~clk;

  ckwd_top u0 (
    .clk(clk), .rst_n(rst_n), .kick(kick), .idx(idx), .tmo(tmo),
    .last_idx(last_idx), .exc_thresh(exc_thresh), .rec_ack(rec_ack),
    .exc_pulse(exc_pulse), .exc_order(exc_order), .rec_req(rec_req),
    .rec_full(rec_full), .fault_valid(fault_valid), .fault_layer(fault_layer),
    .fault_idx(fault_idx), .fault_order(fault_order)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit started = 0;
  string cur_req = "R11";

  // behavioural reference
  int m_cnt[2], m_exp[2], m_good[2], m_frz[2], m_exc[2], m_ord[2];
  int q_lay[$], q_ord[$], q_good[$];

  function automatic int eff_thr(int t);
    if (t == 0) return 1;
    if (t > 4) return 4;
    return t;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      for (int l = 0; l < 2; l++) begin
        m_cnt[l] = 0; m_exp[l] = 0; m_good[l] = 0;
        m_frz[l] = 0; m_exc[l] = 0; m_ord[l] = 0;
      end
      q_lay.delete(); q_ord.delete(); q_good.delete();
    end else begin
      bit clr;
      clr = rec_ack && (q_lay.size() > 0);
      if (clr) begin
        q_lay.delete(); q_ord.delete(); q_good.delete();
      end else begin
        for (int l = 0; l < 2; l++)
          if (m_exc[l] != 0 && q_lay.size() < 4) begin
            q_lay.push_back(l); q_ord.push_back(m_ord[l]); q_good.push_back(m_good[l]);
          end
      end
      for (int l = 0; l < 2; l++) begin
        int t, lst, ki;
        bit ok, hit;
        t   = int'(tmo[l*16 +: 16]); if (t == 0) t = 1;
        lst = int'(last_idx[l*4 +: 4]);
        ki  = int'(idx[l*4 +: 4]);
        if (clr) begin
          m_cnt[l] = 0; m_exp[l] = 0; m_good[l] = 0; m_frz[l] = 0; m_exc[l] = 0; m_ord[l] = 0;
        end else if (m_frz[l] != 0) begin
          m_exc[l] = 0; m_ord[l] = 0;
        end else begin
          ok  = kick[l] && (ki == m_exp[l]);
          hit = !ok && (m_cnt[l] >= t - 1);
          m_exc[l] = (hit || (kick[l] && !ok)) ? 1 : 0;
          m_ord[l] = (!hit && kick[l] && !ok) ? 1 : 0;
          if (ok) begin
            m_cnt[l] = 0; m_good[l] = ki; m_exp[l] = (ki == lst) ? 0 : (ki + 1) % 16;
          end else if (hit) m_frz[l] = 1;
          else m_cnt[l]++;
        end
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", cur_req, what, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      int thr, v;
      thr = eff_thr(int'(exc_thresh));
      v = (q_lay.size() >= thr) ? 1 : 0;
      chk("exc_pulse", int'(exc_pulse), m_exc[1]*2 + m_exc[0]);
      chk("exc_order", int'(exc_order), m_exc[1]*m_ord[1]*2 + m_exc[0]*m_ord[0]);
      chk("rec_req", int'(rec_req), (q_lay.size() > 0) ? 1 : 0);
      chk("rec_full", int'(rec_full), v);
      chk("fault_valid", int'(fault_valid), v);
      chk("fault_layer", int'(fault_layer), v ? (1 << q_lay[0]) : 0);
      chk("fault_idx", int'(fault_idx), v ? q_good[0] : 0);
      chk("fault_order", int'(fault_order), v ? q_ord[0] : 0);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic kick_with(int l, int v);
    kick[l] = 1'b1;
    idx[l*4 +: 4] = 4'(v);
    step(1);
    kick[l] = 1'b0;
  endtask

  task automatic kick_good(int l);
    kick_with(l, m_exp[l]);
  endtask

  task automatic kick_bad(int l);
    int len;
    len = int'(last_idx[l*4 +: 4]) + 1;
    kick_with(l, (m_exp[l] + 1) % len);
  endtask

  task automatic ack;
    rec_ack = 1'b1;
    step(1);
    rec_ack = 1'b0;
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cycles > 20000);
    errors++;
    $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cycles);
    finish_run();
  end

  initial begin
    tmo      = {16'd40, 16'd6};
    last_idx = {4'd2, 4'd5};
    exc_thresh = 3'd3;
    step(3);
    cur_req = "R11";
    chk("reset exc_pulse", int'(exc_pulse), 0);
    chk("reset rec_req", int'(rec_req), 0);
    chk("reset fault_valid", int'(fault_valid), 0);
    rst_n = 1'b1;
    started = 1;
    step(2);

    // R2 and R6: clean passes on both layers, with wraparound
    cur_req = "R2";
    for (int k = 0; k < 14; k++) begin
      kick_good(0);
      if (k % 2 == 1) kick_good(1); else step(1);
      step(1);
    end
    chk("no request after clean passes", int'(rec_req), 0);

    // R3 and R8: one order violation requests a retry
    cur_req = "R3";
    kick_bad(0);
    step(2);
    cur_req = "R8";
    chk("retry request", int'(rec_req), 1);
    chk("retry not full", int'(rec_full), 0);
    cur_req = "R10";
    ack();
    chk("cleared by ack", int'(rec_req), 0);

    // R1, R4 and R6: inner stalls, outer keeps going
    cur_req = "R1";
    for (int k = 0; k < 4; k++) begin
      kick_good(1);
      step(2);
    end
    cur_req = "R4";
    kick_good(0);
    step(2);
    kick_bad(0);
    cur_req = "R6";
    for (int k = 0; k < 3; k++) begin
      kick_good(1);
      step(3);
    end
    chk("single stall recorded once", int'(fault_valid), 0);
    chk("stall request", int'(rec_req), 1);
    cur_req = "R10";
    ack();

    // R5: wrong kick on the expiry edge is a timeout
    cur_req = "R5";
    step(5);
    kick_bad(0);
    chk("timeout wins", int'(exc_order), 0);
    chk("timeout pulse", int'(exc_pulse), 1);
    step(2);
    ack();

    // R7: simultaneous exceptions, inner stored first
    cur_req = "R7";
    tmo = {16'd40, 16'd12};
    exc_thresh = 3'd1;
    kick[0] = 1'b1; kick[1] = 1'b1;
    idx = {4'(m_exp[1] + 1), 4'(m_exp[0] + 1)};
    step(1);
    kick = '0;
    step(1);
    chk("inner first", int'(fault_layer), 1);
    ack();

    // R9: outer first, location and last good index
    cur_req = "R9";
    exc_thresh = 3'd2;
    kick_good(1);
    kick_good(1);
    kick_bad(1);
    kick_bad(0);
    step(2);
    chk("outer located", int'(fault_layer), 2);
    chk("outer order", int'(fault_order), 1);
    chk("outer last good", int'(fault_idx), 1);
    ack();

    // R8: threshold clamping
    cur_req = "R8";
    exc_thresh = 3'd0;
    kick_bad(0);
    step(2);
    chk("zero threshold acts as one", int'(rec_full), 1);
    ack();
    exc_thresh = 3'd7;
    kick_bad(0); kick_bad(0); kick_bad(0);
    step(2);
    chk("three below clamped four", int'(rec_full), 0);
    kick_bad(0);
    step(2);
    chk("four reaches clamped four", int'(rec_full), 1);
    ack();

    // R10: exception colliding with acknowledge is dropped
    cur_req = "R10";
    exc_thresh = 3'd3;
    kick_bad(0);
    step(2);
    rec_ack = 1'b1;
    kick[0] = 1'b1;
    idx[3:0] = 4'(m_exp[0] + 1);
    step(1);
    rec_ack = 1'b0;
    kick = '0;
    step(3);
    chk("collision dropped", int'(rec_req), 0);
    step(4);
    finish_run();
  end
endmodule